// File: doc/BRIEF.md
# FIFO-Occupancy Oscillator Trim Controller

This block keeps an audio sample buffer close to half full. It does this by nudging an unsigned tuning word for the local master oscillator. It runs entirely in the master-clock domain. Its inputs are the buffer's fill count and a periodic update strobe. Its output drives an external tuning DAC.

The block deliberately does not behave like a phase-locked loop. It never reacts to the short-term timing of the incoming stream. Each update strobe can move the word by one quantization step at most. A programmable dead band around the half-full point suppresses steps while occupancy is acceptable. A programmable minimum spacing between steps caps the slew rate, which gives the loop a very low effective bandwidth.

Two sticky flags record that the buffer came close to full or close to empty. Each flag stays set until its own clear pulse removes it. With the default 4096-entry buffer and a 10-bit word, steps of about 0.4 ppm cover a ±200 ppm window at 12.288 MHz.

Top module: `fifo_trim_ctrl`

## Requirements
- R1: While `rst` is high, `trim_word` loads `cfg_mid` and both sticky flags and `fill_in_band` read 0. The spacing counter is also cleared, so the first qualifying strobe after reset can step at once.
- R2: The target is DEPTH/2. When |`fill_level` − target| ≤ `cfg_deadband`, a strobe leaves `trim_word` unchanged, and `fill_in_band` reads 1 two cycles after that fill is presented.
- R3: When `fill_level` > target + `cfg_deadband`, a strobe raises `trim_word` by exactly 1. The new value appears two clock edges after the edge that samples `upd_tick`.
- R4: When `fill_level` + `cfg_deadband` < target, a strobe lowers `trim_word` by exactly 1, with the same two-edge latency.
- R5: `trim_word` changes only in response to `upd_tick`. With the strobe low it holds, whatever the fill level.
- R6: Two consecutive changes of `trim_word` lie at least `cfg_interval`+1 clock edges apart. A strobe that arrives sooner is ignored, and it does not restart the spacing count.
- R7: At all-ones, an upward request leaves `trim_word` at all-ones. It never wraps to zero.
- R8: At zero, a downward request leaves `trim_word` at zero. It never wraps to all-ones.
- R9: `near_full_flag` sets two cycles after `fill_level` > `cfg_near_full` is presented. It stays set after the fill returns, until a `clr_full_flag` pulse clears it. A fill equal to the threshold does not set it.
- R10: `near_empty_flag` sets two cycles after `fill_level` < `cfg_near_empty` is presented. It stays set until a `clr_empty_flag` pulse clears it. A fill equal to the threshold does not set it.
- R11: If a flag's set condition holds in the same cycle as its clear pulse, the flag stays set.
- R12: Every change of `trim_word` is a change of exactly one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | FILL_W | Buffer occupancy count in the master domain |
| upd_tick | input | 1 | One-cycle update strobe |
| cfg_mid | input | CW_W | Tuning word loaded at reset |
| cfg_deadband | input | FILL_W | Half-width of the no-step band around target |
| cfg_interval | input | IVL_W | Minimum clock count between steps |
| cfg_near_full | input | FILL_W | Near-full threshold |
| cfg_near_empty | input | FILL_W | Near-empty threshold |
| clr_full_flag | input | 1 | Clears the near-full flag |
| clr_empty_flag | input | 1 | Clears the near-empty flag |
| trim_word | output | CW_W | Oscillator tuning word |
| near_full_flag | output | 1 | Sticky near-full indication |
| near_empty_flag | output | 1 | Sticky near-empty indication |
| fill_in_band | output | 1 | Fill is inside the dead band |

## Verification
The bench keeps the real depth of 4096, so the fill thresholds and dead-band edges are exercised at their true values. It narrows the tuning word to 4 bits, which brings both saturation rails within one or two steps of a chosen reset value. It also narrows the spacing counter to 8 bits with an interval of 3. That short interval lets a single run show a too-early strobe being rejected and a later strobe being accepted.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } trim_dir_e;
endpackage

// File: rtl/trim_fill_cmp.sv
module trim_fill_cmp
  import trim_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int FILL_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] fill_level,
  input  logic              upd_tick,
  input  logic [FILL_W-1:0] cfg_deadband,
  input  logic [FILL_W-1:0] cfg_near_full,
  input  logic [FILL_W-1:0] cfg_near_empty,
  output trim_dir_e         dir_q,
  output logic              tick_q,
  output logic              in_band_q,
  output logic              above_q,
  output logic              below_q
);
  localparam logic [FILL_W:0] TARGET = (FILL_W+1)'(DEPTH / 2);

  logic [FILL_W:0] fill_x;
  logic [FILL_W:0] upper_edge;
  logic [FILL_W:0] fill_plus_db;
  logic            want_up;
  logic            want_down;
  trim_dir_e       dir_d;

  always_comb begin
    fill_x       = {1'b0, fill_level};
    upper_edge   = TARGET + {1'b0, cfg_deadband};
    fill_plus_db = fill_x + {1'b0, cfg_deadband};
    want_up      = fill_x > upper_edge;
    want_down    = fill_plus_db < TARGET;
    if (want_up)        dir_d = DIR_UP;
    else if (want_down) dir_d = DIR_DOWN;
    else                dir_d = DIR_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= DIR_HOLD;
      tick_q    <= 1'b0;
      in_band_q <= 1'b0;
      above_q   <= 1'b0;
      below_q   <= 1'b0;
    end else begin
      dir_q     <= dir_d;
      tick_q    <= upd_tick;
      in_band_q <= !want_up && !want_down;
      above_q   <= fill_level > cfg_near_full;
      below_q   <= fill_level < cfg_near_empty;
    end
  end

  // R2: a registered in-band result never coexists with a step direction
  a_r2_band_no_dir: assert property (@(posedge clk) disable iff (rst)
    in_band_q |-> (dir_q == DIR_HOLD));
endmodule

// File: rtl/trim_slew_gate.sv
module trim_slew_gate #(
  parameter int IVL_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic             stepped,
  output logic             open
);
  logic [IVL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (stepped)      cnt <= cfg_interval;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign open = (cnt == '0);

  // R6: the spacing count only runs down between steps
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (!stepped && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/trim_word_acc.sv
module trim_word_acc
  import trim_pkg::*;
#(
  parameter int CW_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW_W-1:0] cfg_mid,
  input  logic            tick_q,
  input  logic            open,
  input  trim_dir_e       dir_q,
  output logic            stepped,
  output logic [CW_W-1:0] word
);
  localparam logic [CW_W-1:0] TOP = '1;

  logic go_up;
  logic go_down;

  always_comb begin
    go_up   = tick_q && open && (dir_q == DIR_UP)   && (word != TOP);
    go_down = tick_q && open && (dir_q == DIR_DOWN) && (word != '0);
    stepped = go_up || go_down;
  end

  always_ff @(posedge clk) begin
    if (rst)          word <= cfg_mid;
    else if (go_up)   word <= word + 1'b1;
    else if (go_down) word <= word - 1'b1;
  end

  // R12: one LSB at most per edge
  a_r12_unit_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (word == $past(word) || word == $past(word) + 1 || word == $past(word) - 1));
  // R7: top rail holds
  a_r7_no_wrap_high: assert property (@(posedge clk) disable iff (rst)
    (word == TOP) |=> (word != '0));
  // R8: bottom rail holds
  a_r8_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
    (word == '0) |=> (word != TOP));
endmodule

// File: rtl/trim_sticky_flag.sv
module trim_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_cond,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set_cond || (flag && !clr);
  end

  // R9/R10: a set flag persists without a clear
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R11: setting wins over clearing
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_cond |=> flag);
endmodule

// File: rtl/fifo_trim_ctrl.sv
module fifo_trim_ctrl
  import trim_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int FILL_W = $clog2(DEPTH) + 1,
  parameter int CW_W   = 10,
  parameter int IVL_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] fill_level,
  input  logic              upd_tick,
  input  logic [CW_W-1:0]   cfg_mid,
  input  logic [FILL_W-1:0] cfg_deadband,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic [FILL_W-1:0] cfg_near_full,
  input  logic [FILL_W-1:0] cfg_near_empty,
  input  logic              clr_full_flag,
  input  logic              clr_empty_flag,
  output logic [CW_W-1:0]   trim_word,
  output logic              near_full_flag,
  output logic              near_empty_flag,
  output logic              fill_in_band
);
  trim_dir_e dir_q;
  logic      tick_q;
  logic      above_q;
  logic      below_q;
  logic      open;
  logic      stepped;

  trim_fill_cmp #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_cmp (
    .clk(clk), .rst(rst), .fill_level(fill_level), .upd_tick(upd_tick),
    .cfg_deadband(cfg_deadband), .cfg_near_full(cfg_near_full),
    .cfg_near_empty(cfg_near_empty), .dir_q(dir_q), .tick_q(tick_q),
    .in_band_q(fill_in_band), .above_q(above_q), .below_q(below_q)
  );

  trim_slew_gate #(.IVL_W(IVL_W)) u_gate (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval),
    .stepped(stepped), .open(open)
  );

  trim_word_acc #(.CW_W(CW_W)) u_acc (
    .clk(clk), .rst(rst), .cfg_mid(cfg_mid), .tick_q(tick_q), .open(open),
    .dir_q(dir_q), .stepped(stepped), .word(trim_word)
  );

  trim_sticky_flag u_full (
    .clk(clk), .rst(rst), .set_cond(above_q), .clr(clr_full_flag),
    .flag(near_full_flag)
  );

  trim_sticky_flag u_empty (
    .clk(clk), .rst(rst), .set_cond(below_q), .clr(clr_empty_flag),
    .flag(near_empty_flag)
  );

  // Port-level checks on spacing and strobe dependence
  logic [CW_W-1:0]  word_d;
  logic             word_chg;
  logic [IVL_W:0]   since;
  logic             armed;

  always_ff @(posedge clk) word_d <= trim_word;
  assign word_chg = (trim_word != word_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      armed <= 1'b0;
    end else if (word_chg) begin
      since <= '0;
      armed <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  // R6: changes spaced by more than the interval
  a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
    (word_chg && armed) |-> (since >= {1'b0, cfg_interval}));
  // R5: a change needs a strobe two edges earlier
  a_r5_tick_only: assert property (@(posedge clk) disable iff (rst)
    (trim_word != $past(trim_word)) |-> $past(upd_tick, 2));
endmodule

// File: tb/sim_fifo_trim_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_trim_ctrl;
  localparam int DEPTH  = 4096;
  localparam int FILL_W = 13;
  localparam int CW_W   = 4;
  localparam int IVL_W  = 8;
  localparam int TGT    = DEPTH / 2;
  localparam int DB     = 16;
  localparam int IVL    = 3;
  localparam int NF     = 4000;
  localparam int NE     = 100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [FILL_W-1:0] fill_level = FILL_W'(TGT);
  logic              upd_tick = 1'b0;
  logic [CW_W-1:0]   cfg_mid = 4'd8;
  logic [FILL_W-1:0] cfg_deadband = FILL_W'(DB);
  logic [IVL_W-1:0]  cfg_interval = IVL_W'(IVL);
  logic [FILL_W-1:0] cfg_near_full = FILL_W'(NF);
  logic [FILL_W-1:0] cfg_near_empty = FILL_W'(NE);
  logic              clr_full_flag = 1'b0;
  logic              clr_empty_flag = 1'b0;
  logic [CW_W-1:0]   trim_word;
  logic              near_full_flag;
  logic              near_empty_flag;
  logic              fill_in_band;

  fifo_trim_ctrl #(.DEPTH(DEPTH), .FILL_W(FILL_W), .CW_W(CW_W), .IVL_W(IVL_W)) u0 (
    .clk(clk), .rst(rst), .fill_level(fill_level), .upd_tick(upd_tick),
    .cfg_mid(cfg_mid), .cfg_deadband(cfg_deadband), .cfg_interval(cfg_interval),
    .cfg_near_full(cfg_near_full), .cfg_near_empty(cfg_near_empty),
    .clr_full_flag(clr_full_flag), .clr_empty_flag(clr_empty_flag),
    .trim_word(trim_word), .near_full_flag(near_full_flag),
    .near_empty_flag(near_empty_flag), .fill_in_band(fill_in_band)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    word;
    bit    fhi;
    bit    flo;
    bit    inb;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  int   m_word;
  bit   m_fhi, m_flo;
  bit   have_last;
  int   last_chg;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit in_band(int f);
    return (f <= TGT + DB) && (f + DB >= TGT);
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.word = m_word; e.fhi = m_fhi; e.flo = m_flo;
    e.inb = in_band(int'(fill_level)); e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares queued expectations 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(trim_word) != e.word || near_full_flag != e.fhi ||
            near_empty_flag != e.flo || fill_in_band != e.inb) begin
          errors++;
          $display("FAIL %s: actual word=%0d fhi=%0b flo=%0b inb=%0b expected word=%0d fhi=%0b flo=%0b inb=%0b",
                   e.tag, trim_word, near_full_flag, near_empty_flag, fill_in_band,
                   e.word, e.fhi, e.flo, e.inb);
        end
      end
    end
  end

  task automatic do_reset(int mid, string tag);
    @(negedge clk);
    rst = 1'b1;
    cfg_mid = CW_W'(mid);
    fill_level = FILL_W'(TGT);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_word = mid; m_fhi = 0; m_flo = 0; have_last = 0;
    repeat (2) @(negedge clk);
    push(tag);
  endtask

  task automatic set_fill(int f, string tag);
    @(negedge clk);
    fill_level = FILL_W'(f);
    if (f > NF) m_fhi = 1;
    if (f < NE) m_flo = 1;
    repeat (2) @(negedge clk);
    push(tag);
  endtask

  task automatic tick(string tag);
    int f;
    @(negedge clk);
    upd_tick = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0;
    @(negedge clk);
    f = int'(fill_level);
    if (!have_last || (cyc - last_chg) >= IVL + 1) begin
      if (f > TGT + DB && m_word != (1 << CW_W) - 1) begin
        m_word++; have_last = 1; last_chg = cyc;
      end else if (f + DB < TGT && m_word != 0) begin
        m_word--; have_last = 1; last_chg = cyc;
      end
    end
    push(tag);
  endtask

  task automatic clr_pulse(bit full, string tag);
    @(negedge clk);
    if (full) clr_full_flag = 1'b1; else clr_empty_flag = 1'b1;
    @(negedge clk);
    clr_full_flag = 1'b0; clr_empty_flag = 1'b0;
    if (full) m_fhi = (int'(fill_level) > NF);
    else      m_flo = (int'(fill_level) < NE);
    push(tag);
  endtask

  initial begin
    do_reset(8, "R1 reset state");
    tick("R2 target fill holds");
    set_fill(TGT + DB, "R2 upper band edge");
    tick("R2 upper edge no step");
    set_fill(TGT - DB, "R2 lower band edge");
    tick("R2 lower edge no step");
    set_fill(TGT + DB + 1, "R3 fill above band");
    tick("R3 R1 first step right after reset");
    tick("R6 early strobe ignored");
    repeat (10) @(negedge clk);
    tick("R6 R3 strobe after interval");
    repeat (20) @(negedge clk);
    push("R5 no strobe no change");
    set_fill(TGT - DB - 1, "R4 fill below band");
    repeat (6) @(negedge clk);
    tick("R4 step down");
    repeat (6) @(negedge clk);
    tick("R4 second step down");
    set_fill(TGT, "R2 back in band");
    do_reset(14, "R1 reset with high mid");
    set_fill(TGT + 500, "R7 push up");
    tick("R7 reach top");
    repeat (6) @(negedge clk);
    tick("R7 top holds");
    repeat (6) @(negedge clk);
    tick("R7 top still holds");
    do_reset(1, "R1 reset with low mid");
    set_fill(TGT - 500, "R8 push down");
    tick("R8 reach zero");
    repeat (6) @(negedge clk);
    tick("R8 zero holds");
    do_reset(8, "R1 reset before flags");
    set_fill(NF, "R9 threshold does not set");
    set_fill(NF + 1, "R9 above threshold sets");
    set_fill(TGT, "R9 flag sticks");
    clr_pulse(1'b1, "R9 clear");
    set_fill(NF + 1, "R11 set again");
    clr_pulse(1'b1, "R11 set beats clear");
    set_fill(TGT, "R11 fill back");
    clr_pulse(1'b1, "R9 cleared after fill back");
    set_fill(NE, "R10 threshold does not set");
    set_fill(NE - 1, "R10 below threshold sets");
    set_fill(TGT, "R10 flag sticks");
    clr_pulse(1'b0, "R10 clear");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule